// File: doc/BRIEF.md
# Predicated Vector Load/Store Sequencer

This block carries out one contiguous, non-widening transfer between memory and a single 128-bit vector register. The element width is a byte, a halfword or a word. On issue it decodes the addressing fields: a 7-bit immediate scaled by the element size, an add/subtract choice, pre-indexing and base writeback. It also screens out encodings that are not legal. It then walks the register element by element and issues one memory request for each lane whose predicate bit is set. Each request waits for its acknowledge before the next one is issued.

Lanes that are predicated off make no memory access. The element address still advances past them, so the memory footprint of the instruction does not depend on the predicate. When the last element has been handled, a one-cycle completion pulse presents the merged register value (for loads) and the updated base value (when writeback is enabled). Writeback happens even if every lane was masked off.

Top module: `vec_ldst_seq`

## Requirements
- R1: The byte offset is the immediate shifted left by the size code (0 = byte, 1 = halfword, 2 = word). It is subtracted from the base when the add input is low and added when it is high.
- R2: With pre-indexing, element 0 is addressed at base plus offset. Without pre-indexing, element 0 is addressed at the base value itself.
- R3: With writeback enabled, wb_en is high during the done cycle and wb_val equals base plus offset, whatever the lane mask. Without writeback, wb_en stays low.
- R4: The instruction is undefined in each of these cases: base index 15; base index 13 with writeback; vector index 8 or above; size code 3; pre-index and writeback both low. In that case undef pulses for one cycle, one cycle after start, and no memory request, no done and no writeback follow.
- R5: Element e is active exactly when lane_mask bit e·esize is 1, where esize is 1, 2 or 4 bytes. Exactly one memory request is made for each active element, and none for an inactive one.
- R6: Element e is addressed at the first address plus e·esize, whether or not earlier elements were active. mem_size carries the size code.
- R7: On a load, each active element takes the low esize bytes of mem_rdata. Inactive elements keep the contents of qreg_rdata. The result is presented on qreg_wdata with qreg_we during the done cycle.
- R8: On a store, mem_we is high and mem_wdata carries element e, zero-extended. Element e is taken little-endian from qreg_rdata bits [8·e·esize +: 8·esize].
- R9: Only one request is outstanding at a time. Once raised, mem_req and mem_addr stay unchanged until the cycle in which mem_ack is seen.
- R10: done pulses for exactly one cycle, in the cycle after the last element completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue the instruction presented on the field inputs (accepted when idle) |
| is_load | input | 1 | 1 = memory to register, 0 = register to memory |
| elem_size | input | 2 | Element size code: 0 byte, 1 halfword, 2 word, 3 illegal |
| imm7 | input | 7 | Unsigned immediate offset in elements |
| add_off | input | 1 | 1 = add offset, 0 = subtract offset |
| pre_index | input | 1 | Apply offset before the first access |
| wback | input | 1 | Write base plus offset back to the base register |
| base_idx | input | 4 | Base register index |
| qreg_idx | input | 4 | Vector register index (must be below 8) |
| base_val | input | 32 | Current base register value |
| lane_mask | input | 16 | Per-byte-lane predicate |
| qreg_rdata | input | 128 | Current vector register contents |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_size | output | 2 | Request size code |
| mem_wdata | output | 32 | Store data, right aligned |
| mem_ack | input | 1 | Request accepted and completed |
| mem_rdata | input | 32 | Load data, right aligned, valid with mem_ack |
| qreg_we | output | 1 | Vector register write enable (loads, done cycle) |
| qreg_wdata | output | 128 | Merged vector register value |
| wb_en | output | 1 | Base register write enable (done cycle) |
| wb_val | output | 32 | New base value |
| undef | output | 1 | Undefined-instruction pulse |
| done | output | 1 | Completion pulse |

## Verification
Random instructions vary size, immediate, sign, indexing mode, base value, mask and register contents, and the memory acknowledge comes after random delays of zero to two cycles. Comparing each request's address with the model separates the offset sign and scaling, the pre/post-index choice and the unconditional per-element step. An all-zero mask with writeback, and a full mask near address zero with a subtracted offset, show that writeback and address wraparound do not depend on the lanes. Each illegal encoding is issued on its own to show that it is rejected without any access, and mixed masks on loads show which bytes are merged and which are kept.

// File: rtl/vldst_pkg.sv
package vldst_pkg;
    localparam int VBYTES = 16;
    localparam int VBITS  = VBYTES * 8;
    localparam int IDX_W  = $clog2(VBYTES);
    localparam int AW     = 32;
    localparam int MW     = 32;
    localparam int IMM_W  = 7;
    localparam int RIDX_W = 4;
    localparam int NQREG  = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_st_e;

    typedef struct packed {
        seq_st_e           st;
        logic [AW-1:0]     addr;
        logic [IDX_W-1:0]  elem;
        logic [1:0]        size;
        logic              load;
        logic              wb;
        logic [AW-1:0]     wb_val;
        logic [VBYTES-1:0] mask;
        logic [VBITS-1:0]  vec;
        logic              undef;
    } seq_ctx_t;
endpackage

// File: rtl/vldst_decode.sv
module vldst_decode
    import vldst_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [IMM_W-1:0]  imm,
    input  logic              add_off,
    input  logic              pre_index,
    input  logic              wback,
    input  logic [RIDX_W-1:0] base_idx,
    input  logic [RIDX_W-1:0] qreg_idx,
    input  logic [AW-1:0]     base_val,
    output logic              illegal,
    output logic [AW-1:0]     first_addr,
    output logic [AW-1:0]     next_base
);
    localparam logic [RIDX_W-1:0] PC_IDX = RIDX_W'(15);
    localparam logic [RIDX_W-1:0] SP_IDX = RIDX_W'(13);

    logic [AW-1:0] mag;
    logic [AW-1:0] off;

    always_comb begin
        mag        = AW'(imm) << size;
        off        = add_off ? mag : (~mag + AW'(1));
        next_base  = base_val + off;
        first_addr = pre_index ? next_base : base_val;
        illegal    = (base_idx == PC_IDX)
                   || (base_idx == SP_IDX && wback)
                   || (32'(qreg_idx) >= NQREG)
                   || (size == 2'd3)
                   || (!pre_index && !wback);
    end
endmodule

// File: rtl/vldst_lane.sv
module vldst_lane
    import vldst_pkg::*;
(
    input  logic [VBYTES-1:0] mask,
    input  logic [1:0]        size,
    input  logic [IDX_W-1:0]  elem,
    output logic              active,
    output logic              last,
    output logic [AW-1:0]     step
);
    logic [IDX_W-1:0] lane_bit;
    logic [IDX_W:0]   count;

    always_comb begin
        lane_bit = IDX_W'(elem << size);
        count    = (IDX_W+1)'(VBYTES) >> size;
        active   = mask[lane_bit];
        last     = ({1'b0, elem} == count - (IDX_W+1)'(1));
        step     = AW'(1) << size;
    end
endmodule

// File: rtl/vldst_lane_data.sv
module vldst_lane_data
    import vldst_pkg::*;
(
    input  logic [VBITS-1:0] vec,
    input  logic [1:0]       size,
    input  logic [IDX_W-1:0] elem,
    input  logic [MW-1:0]    rdata,
    output logic [VBITS-1:0] merged,
    output logic [MW-1:0]    store_word
);
    localparam int SH_W = $clog2(VBITS);

    logic [IDX_W-1:0] byte0;
    logic [SH_W-1:0]  bit_sh;
    logic [VBITS-1:0] shifted;
    logic [MW-1:0]    keep;

    always_comb begin
        byte0      = IDX_W'(elem << size);
        bit_sh     = {byte0, 3'b000};
        shifted    = vec >> bit_sh;
        keep       = (size == 2'd0) ? MW'(32'h0000_00FF)
                   : (size == 2'd1) ? MW'(32'h0000_FFFF) : MW'(32'hFFFF_FFFF);
        store_word = shifted[MW-1:0] & keep;
    end

    for (genvar b = 0; b < VBYTES; b++) begin : g_byte
        localparam logic [IDX_W-1:0] BIDX = IDX_W'(b);
        logic       hit;
        logic [1:0] src;
        always_comb begin
            hit = ((BIDX >> size) == elem);
            case (size)
                2'd0:    src = 2'd0;
                2'd1:    src = {1'b0, BIDX[0]};
                default: src = BIDX[1:0];
            endcase
            merged[b*8 +: 8] = hit ? rdata[src*8 +: 8] : vec[b*8 +: 8];
        end
    end
endmodule

// File: rtl/vec_ldst_seq.sv
module vec_ldst_seq
    import vldst_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               is_load,
    input  logic [1:0]         elem_size,
    input  logic [IMM_W-1:0]   imm7,
    input  logic               add_off,
    input  logic               pre_index,
    input  logic               wback,
    input  logic [RIDX_W-1:0]  base_idx,
    input  logic [RIDX_W-1:0]  qreg_idx,
    input  logic [AW-1:0]      base_val,
    input  logic [VBYTES-1:0]  lane_mask,
    input  logic [VBITS-1:0]   qreg_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [1:0]         mem_size,
    output logic [MW-1:0]      mem_wdata,
    input  logic               mem_ack,
    input  logic [MW-1:0]      mem_rdata,
    output logic               qreg_we,
    output logic [VBITS-1:0]   qreg_wdata,
    output logic               wb_en,
    output logic [AW-1:0]      wb_val,
    output logic               undef,
    output logic               done
);
    seq_ctx_t ctx_d, ctx_q;

    logic             dec_illegal;
    logic [AW-1:0]    dec_first;
    logic [AW-1:0]    dec_next;
    logic             lane_act;
    logic             lane_last;
    logic [AW-1:0]    lane_step;
    logic [VBITS-1:0] merged;
    logic [MW-1:0]    store_word;
    logic             adv;

    vldst_decode u_decode (
        .size       (elem_size),
        .imm        (imm7),
        .add_off    (add_off),
        .pre_index  (pre_index),
        .wback      (wback),
        .base_idx   (base_idx),
        .qreg_idx   (qreg_idx),
        .base_val   (base_val),
        .illegal    (dec_illegal),
        .first_addr (dec_first),
        .next_base  (dec_next)
    );

    vldst_lane u_lane (
        .mask   (ctx_q.mask),
        .size   (ctx_q.size),
        .elem   (ctx_q.elem),
        .active (lane_act),
        .last   (lane_last),
        .step   (lane_step)
    );

    vldst_lane_data u_data (
        .vec        (ctx_q.vec),
        .size       (ctx_q.size),
        .elem       (ctx_q.elem),
        .rdata      (mem_rdata),
        .merged     (merged),
        .store_word (store_word)
    );

    always_comb begin
        ctx_d       = ctx_q;
        ctx_d.undef = 1'b0;
        adv         = 1'b0;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (dec_illegal) begin
                        ctx_d.undef = 1'b1;
                    end else begin
                        ctx_d.st     = ST_RUN;
                        ctx_d.addr   = dec_first;
                        ctx_d.elem   = '0;
                        ctx_d.size   = elem_size;
                        ctx_d.load   = is_load;
                        ctx_d.wb     = wback;
                        ctx_d.wb_val = dec_next;
                        ctx_d.mask   = lane_mask;
                        ctx_d.vec    = qreg_rdata;
                    end
                end
            end
            ST_RUN: begin
                adv = !lane_act || mem_ack;
                if (lane_act && mem_ack && ctx_q.load) begin
                    ctx_d.vec = merged;
                end
                if (adv) begin
                    ctx_d.addr = ctx_q.addr + lane_step;
                    if (lane_last) begin
                        ctx_d.st = ST_FIN;
                    end else begin
                        ctx_d.elem = ctx_q.elem + IDX_W'(1);
                    end
                end
            end
            ST_FIN: begin
                ctx_d.st = ST_IDLE;
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    always_comb begin
        mem_req    = (ctx_q.st == ST_RUN) && lane_act;
        mem_we     = mem_req && !ctx_q.load;
        mem_addr   = ctx_q.addr;
        mem_size   = ctx_q.size;
        mem_wdata  = ctx_q.load ? '0 : store_word;
        done       = (ctx_q.st == ST_FIN);
        qreg_we    = done && ctx_q.load;
        qreg_wdata = ctx_q.vec;
        wb_en      = done && ctx_q.wb;
        wb_val     = ctx_q.wb_val;
        undef      = ctx_q.undef;
    end

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_undef_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (!mem_req && !done && !wb_en));

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctx_q.st == ST_RUN) && adv) |=>
            (ctx_q.addr == $past(ctx_q.addr) + (AW'(1) << $past(ctx_q.size))));

    assert_qwrite_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        qreg_we |-> (done && !mem_req));
endmodule

// File: tb/vec_ldst_seq_bench.sv
`timescale 1ns/1ps
module vec_ldst_seq_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         is_load = 1'b0;
    logic [1:0]   elem_size = '0;
    logic [6:0]   imm7 = '0;
    logic         add_off = 1'b0;
    logic         pre_index = 1'b0;
    logic         wback = 1'b0;
    logic [3:0]   base_idx = '0;
    logic [3:0]   qreg_idx = '0;
    logic [31:0]  base_val = '0;
    logic [15:0]  lane_mask = '0;
    logic [127:0] qreg_rdata = '0;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [1:0]   mem_size;
    logic [31:0]  mem_wdata;
    logic         mem_ack = 1'b0;
    logic [31:0]  mem_rdata = '0;
    logic         qreg_we;
    logic [127:0] qreg_wdata;
    logic         wb_en;
    logic [31:0]  wb_val;
    logic         undef, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    vec_ldst_seq u_vec_ldst_seq (.*);

    always #5 clk = ~clk;

    logic [31:0]  r_addr  [16];
    logic         r_we    [16];
    logic [31:0]  r_wdata [16];
    logic [1:0]   r_size  [16];
    int           nreq;
    logic         got_done, got_undef, c_wb_en, c_qwe, saw_any;
    logic [31:0]  c_wb_val;
    logic [127:0] c_qdata;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'hA5C3, ~a[15:0]} ^ {a[31:16], 16'h0};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_op(input logic ld, input logic [1:0] sz, input logic [6:0] im,
                          input logic ad, input logic pr, input logic wb,
                          input logic [3:0] bi, input logic [3:0] qi,
                          input logic [31:0] bv, input logic [15:0] mk,
                          input logic [127:0] qd);
        logic pending;
        int   cnt;
        int   guard;
        @(negedge clk);
        is_load = ld; elem_size = sz; imm7 = im; add_off = ad; pre_index = pr;
        wback = wb; base_idx = bi; qreg_idx = qi; base_val = bv; lane_mask = mk;
        qreg_rdata = qd; start = 1'b1;
        nreq = 0; got_done = 0; got_undef = 0; c_wb_en = 0; c_qwe = 0; saw_any = 0;
        c_wb_val = '0; c_qdata = '0;
        pending = 0; cnt = 0; guard = 0;
        @(negedge clk);
        start = 1'b0;
        while (!got_done && guard < 200) begin
            if (mem_ack) begin mem_ack = 1'b0; pending = 0; end
            if (mem_req && !pending) begin
                if (nreq < 16) begin
                    r_addr[nreq] = mem_addr; r_we[nreq] = mem_we;
                    r_wdata[nreq] = mem_wdata; r_size[nreq] = mem_size;
                end
                nreq++;
                pending = 1;
                cnt = int'($urandom % 3);
            end
            if (pending) begin
                if (cnt == 0) begin mem_ack = 1'b1; mem_rdata = mem_word(mem_addr); end
                else cnt--;
            end
            if (undef) got_undef = 1;
            if (wb_en || qreg_we) saw_any = 1;
            if (done) begin
                got_done = 1; c_wb_en = wb_en; c_wb_val = wb_val;
                c_qwe = qreg_we; c_qdata = qreg_wdata;
            end
            if (got_undef && guard >= 4) break;
            guard++;
            @(negedge clk);
        end
        mem_ack = 1'b0;
    endtask

    task automatic do_legal(input logic ld, input logic [1:0] sz, input logic [6:0] im,
                            input logic ad, input logic pr, input logic wb,
                            input logic [3:0] bi, input logic [3:0] qi,
                            input logic [31:0] bv, input logic [15:0] mk,
                            input logic [127:0] qd);
        int          esz, n, k, nact;
        logic [31:0] off, first, ea, ew;
        logic [127:0] ev;
        logic        order_ok;
        run_op(ld, sz, im, ad, pr, wb, bi, qi, bv, mk, qd);
        esz = 1 << sz; n = 16 >> sz;
        off = 32'(im) << sz;
        if (!ad) off = -off;
        first = pr ? bv + off : bv;
        ev = qd; k = 0; nact = 0; order_ok = 1;
        for (int e = 0; e < n; e++) begin
            ea = first + 32'(e * esz);
            if (mk[e*esz]) begin
                nact++;
                if (k < 16 && k < nreq) begin
                    if (r_addr[k] != ea) begin
                        order_ok = 0;
                        chk(0, "R1 R2 R6 request address", 128'(r_addr[k]), 128'(ea));
                    end
                    if (r_size[k] != sz) order_ok = 0;
                    if (r_we[k] != !ld) order_ok = 0;
                    if (!ld) begin
                        ew = 32'(qd >> (e*esz*8));
                        if (esz == 1) ew = ew & 32'hFF;
                        if (esz == 2) ew = ew & 32'hFFFF;
                        chk(r_wdata[k] == ew, "R8 store data", 128'(r_wdata[k]), 128'(ew));
                    end
                end
                k++;
                if (ld) begin
                    ew = mem_word(ea);
                    for (int j = 0; j < esz; j++) ev[(e*esz+j)*8 +: 8] = ew[j*8 +: 8];
                end
            end
        end
        chk(nreq == nact, "R5 active request count", 128'(nreq), 128'(nact));
        chk(order_ok, "R6 R9 request size/direction", 128'(order_ok), 128'(1));
        chk(got_done, "R10 done seen", 128'(got_done), 128'(1));
        chk(c_wb_en == wb, "R3 writeback enable", 128'(c_wb_en), 128'(wb));
        if (wb) chk(c_wb_val == bv + off, "R3 writeback value", 128'(c_wb_val), 128'(bv + off));
        chk(c_qwe == ld, "R7 register write enable", 128'(c_qwe), 128'(ld));
        if (ld) chk(c_qdata == ev, "R7 merged load data", c_qdata, ev);
        @(negedge clk);
        chk(!done, "R10 done single cycle", 128'(done), 128'(0));
    endtask

    task automatic do_illegal(input logic [1:0] sz, input logic pr, input logic wb,
                              input logic [3:0] bi, input logic [3:0] qi, input string why);
        run_op(1'b1, sz, 7'd3, 1'b1, pr, wb, bi, qi, 32'h100, 16'hFFFF, '1);
        chk(got_undef && nreq == 0 && !got_done && !saw_any,
            {"R4 undefined ", why}, 128'({got_undef, got_done, saw_any}), 128'(3'b100));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!mem_req && !done && !undef && !wb_en && !qreg_we, "R10 reset state",
            128'({mem_req, done, undef, wb_en, qreg_we}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);

        do_illegal(2'd0, 1'b1, 1'b0, 4'd15, 4'd0, "base 15");
        do_illegal(2'd1, 1'b1, 1'b1, 4'd13, 4'd1, "base 13 with writeback");
        do_illegal(2'd2, 1'b1, 1'b0, 4'd2, 4'd8, "vector index 8");
        do_illegal(2'd3, 1'b1, 1'b1, 4'd2, 4'd0, "size 3");
        do_illegal(2'd0, 1'b0, 1'b0, 4'd2, 4'd0, "no pre no writeback");

        // R3 R6: all lanes off, writeback still applied
        do_legal(1'b0, 2'd1, 7'd5, 1'b1, 1'b0, 1'b1, 4'd13 - 4'd1, 4'd2, 32'h2000, 16'h0000,
                 128'h0123_4567_89AB_CDEF_0011_2233_4455_6677);
        // R1 R2: subtracted offset wraps below zero, full mask word load
        do_legal(1'b1, 2'd2, 7'd127, 1'b0, 1'b1, 1'b1, 4'd3, 4'd7, 32'h10, 16'hFFFF,
                 128'hDEAD_BEEF_CAFE_F00D_1234_5678_9ABC_DEF0);
        // R1: base 13 without writeback is legal, byte store, alternating mask
        do_legal(1'b0, 2'd0, 7'd1, 1'b1, 1'b1, 1'b0, 4'd13, 4'd0, 32'hFFFF_FFF8, 16'hAAAA,
                 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0);
        // R5 R7: halfword load, predicate bits on odd lanes only are ignored
        do_legal(1'b1, 2'd1, 7'd9, 1'b1, 1'b1, 1'b0, 4'd4, 4'd1, 32'h400, 16'hAAA5,
                 128'hFFEE_DDCC_BBAA_9988_7766_5544_3322_1100);

        for (int i = 0; i < 60; i++) begin
            logic [1:0] sz;
            logic pr, wb;
            logic [3:0] bi;
            sz = 2'($urandom % 3);
            pr = 1'($urandom);
            wb = pr ? 1'($urandom) : 1'b1;
            bi = 4'($urandom % 13);
            do_legal(1'($urandom), sz, 7'($urandom), 1'($urandom), pr, wb, bi,
                     4'($urandom % 8), $urandom, 16'($urandom),
                     {$urandom, $urandom, $urandom, $urandom});
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule